// File: doc/BRIEF.md
# Comparator Output Event Controller

This block is the digital back end of an on-chip analog comparator. The comparator's result arrives as an asynchronous level. It is 1 when the non-inverting input is above the inverting input, and 0 otherwise. The block brings that level into the bus clock domain through a chain of flip-flops. After each enable it freezes the value it passes downstream for a fixed settling window. It then watches the gated value for the edge kind that software has picked, and records a matching edge in a sticky interrupt flag.

A small register port on the bus clock holds the control settings and returns status. Address 0 is control: bit 0 is enable, bit 1 is interrupt enable, bit 2 is capture enable, bit 3 is pin enable, and bits 5:4 are the edge mode. Address 1 is status: bit 0 is the flag and bit 1 is the gated comparator output. Writing a 1 to status bit 0 clears the flag. The edge mode is encoded as 00 for none, 01 for rising, 10 for falling and 11 for both.

The block has three outputs besides the register port. The interrupt request is the flag qualified by the interrupt enable. The capture line carries the gated, synchronized value to a timer input-capture channel. The pin output carries the raw, unsynchronized comparator level to a pad.

A hold state machine moves through three states:
- OFF: the block is disabled and the counter is held at zero.
- SETTLE: the output is frozen while the counter runs.
- TRACK: the synchronized value is passed through.

Its transitions are:
- OFF→SETTLE, when the enable is seen set.
- SETTLE→TRACK, when the counter reaches the end of the window.
- SETTLE→OFF and TRACK→OFF, whenever the enable is cleared.

Top module: `cmp_event_ctrl`

## Requirements
- R1: After reset, control reads 0, status reads 0, and irq_o, capture_o and pin_o are all 0.
- R2: While enabled and past the settling window, a change on cmp_raw_i reaches status bit 1 and capture_o only after passing through the synchronizer. It is not visible in the same cycle.
- R3: After each 0-to-1 change of the enable bit, the gated output (status bit 1) and the flag keep their values for 63 bus clock cycles.
- R4: The gated state after reset is 0. If the comparator result is 1 during the settling window and the mode is rising, the flag is set once the window ends.
- R5: If the block is disabled and then re-enabled while the result has become the opposite of the held gated value, the edge is seen when the window ends. In falling mode this sets the flag.
- R6: With mode 00, no edge of the gated output sets the flag.
- R7: With mode 01, a rising gated edge sets the flag and a falling edge does not.
- R8: With mode 10, a falling gated edge sets the flag and a rising edge does not.
- R9: With mode 11, both rising and falling gated edges set the flag.
- R10: The flag is sticky. Writing 1 to status bit 0 clears it, and writing 0 to that bit leaves it unchanged.
- R11: When an event and a clearing write occur in the same cycle, the flag stays set.
- R12: irq_o is 1 exactly when control bit 1 and the flag are both 1.
- R13: capture_o equals the gated output ANDed with control bit 2. pin_o equals the raw cmp_raw_i ANDed with control bit 3, with no register on the path.
- R14: While the enable bit is 0, the gated output keeps its last value and the flag is not set by changes on cmp_raw_i.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Bus clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| cmp_raw_i | input | 1 | Asynchronous comparator result |
| reg_wr_i | input | 1 | Register write strobe |
| reg_addr_i | input | 1 | Register select: 0 control, 1 status |
| reg_wdata_i | input | 8 | Register write data |
| reg_rdata_o | output | 8 | Register read data for the selected address |
| irq_o | output | 1 | Interrupt request |
| capture_o | output | 1 | Gated synchronized output for timer capture |
| pin_o | output | 1 | Raw comparator level for a pad |

## Verification
The bench builds the block with its default parameters: a settling window of 63 cycles and a synchronizer two stages deep. With these values the exact end of the window can be reached within a single run. The bench can therefore sample just inside the window, to see that nothing moves yet, and just past it, to see the deferred edge. The short synchronizer puts the edge-versus-clear collision at a fixed, known cycle, so the bench can drive a clearing write into exactly that cycle.

// File: rtl/cmp_evt_pkg.sv
`timescale 1ns/1ps
package cmp_evt_pkg;

    typedef enum logic [1:0] {
        EVT_NONE    = 2'b00,
        EVT_RISE    = 2'b01,
        EVT_FALL    = 2'b10,
        EVT_BOTH    = 2'b11
    } evt_mode_e;

    typedef enum logic [1:0] {
        ST_OFF,
        ST_SETTLE,
        ST_TRACK
    } hold_state_e;

    localparam int REG_W = 8;

endpackage

// File: rtl/cmp_sync.sv
`timescale 1ns/1ps
module cmp_sync #(
    parameter int STAGES = 2
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic d_i,
    output logic q_o
);
    logic [STAGES-1:0] chain_q;

    generate
        for (genvar i = 0; i < STAGES; i++) begin : g_stage
            if (i == 0) begin : g_first
                always_ff @(posedge clk_i or negedge rst_ni) begin
                    if (!rst_ni) chain_q[0] <= 1'b0;
                    else         chain_q[0] <= d_i;
                end
            end else begin : g_next
                always_ff @(posedge clk_i or negedge rst_ni) begin
                    if (!rst_ni) chain_q[i] <= 1'b0;
                    else         chain_q[i] <= chain_q[i-1];
                end
            end
        end
    endgenerate

    assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/cmp_hold_gate.sv
`timescale 1ns/1ps
module cmp_hold_gate
    import cmp_evt_pkg::*;
#(
    parameter int HOLD_CYCLES = 63,
    localparam int CNT_W = $clog2(HOLD_CYCLES + 1)
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              en_i,
    input  logic              sync_i,
    output logic              gated_o,
    output hold_state_e       state_o,
    output logic [CNT_W-1:0]  cnt_o
);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(HOLD_CYCLES - 1);

    hold_state_e state_q, state_d;
    logic [CNT_W-1:0] cnt_q, cnt_d;
    logic gated_q, gated_d;

    // state register
    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            state_q <= ST_OFF;
            cnt_q   <= '0;
            gated_q <= 1'b0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
            gated_q <= gated_d;
        end
    end

    // next state and outputs
    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        gated_d = gated_q;
        unique case (state_q)
            ST_OFF: begin
                cnt_d = '0;
                if (en_i) state_d = ST_SETTLE;
            end
            ST_SETTLE: begin
                if (!en_i) begin
                    state_d = ST_OFF;
                    cnt_d   = '0;
                end else if (cnt_q == LAST) begin
                    state_d = ST_TRACK;
                    cnt_d   = '0;
                end else begin
                    cnt_d = cnt_q + 1'b1;
                end
            end
            ST_TRACK: begin
                gated_d = sync_i;
                if (!en_i) state_d = ST_OFF;
            end
            default: state_d = ST_OFF;
        endcase
    end

    assign gated_o = gated_q;
    assign state_o = state_q;
    assign cnt_o   = cnt_q;
endmodule

// File: rtl/cmp_edge_flag.sv
`timescale 1ns/1ps
module cmp_edge_flag
    import cmp_evt_pkg::*;
(
    input  logic       clk_i,
    input  logic       rst_ni,
    input  logic       gated_i,
    input  evt_mode_e  mode_i,
    input  logic       clr_i,
    output logic       flag_o
);
    logic prev_q;
    logic flag_q;
    logic rise, fall, hit;

    assign rise = gated_i & ~prev_q;
    assign fall = ~gated_i & prev_q;

    always_comb begin
        unique case (mode_i)
            EVT_NONE: hit = 1'b0;
            EVT_RISE: hit = rise;
            EVT_FALL: hit = fall;
            EVT_BOTH: hit = rise | fall;
            default:  hit = 1'b0;
        endcase
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            prev_q <= 1'b0;
            flag_q <= 1'b0;
        end else begin
            prev_q <= gated_i;
            if (hit)        flag_q <= 1'b1;
            else if (clr_i) flag_q <= 1'b0;
        end
    end

    assign flag_o = flag_q;
endmodule

// File: rtl/cmp_event_ctrl.sv
`timescale 1ns/1ps
module cmp_event_ctrl
    import cmp_evt_pkg::*;
#(
    parameter int HOLD_CYCLES = 63,
    parameter int SYNC_STAGES = 2
) (
    input  logic        clk_i,
    input  logic        rst_ni,
    input  logic        cmp_raw_i,
    input  logic        reg_wr_i,
    input  logic        reg_addr_i,
    input  logic [7:0]  reg_wdata_i,
    output logic [7:0]  reg_rdata_o,
    output logic        irq_o,
    output logic        capture_o,
    output logic        pin_o
);
    localparam int CNT_W = $clog2(HOLD_CYCLES + 1);

    logic      en_q, ie_q, cap_q, pin_q;
    evt_mode_e mode_q;
    logic      clr_req;
    logic      sync_val, gated, flag;
    hold_state_e hold_state;
    logic [CNT_W-1:0] hold_cnt;

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            en_q   <= 1'b0;
            ie_q   <= 1'b0;
            cap_q  <= 1'b0;
            pin_q  <= 1'b0;
            mode_q <= EVT_NONE;
        end else if (reg_wr_i && !reg_addr_i) begin
            en_q   <= reg_wdata_i[0];
            ie_q   <= reg_wdata_i[1];
            cap_q  <= reg_wdata_i[2];
            pin_q  <= reg_wdata_i[3];
            mode_q <= evt_mode_e'(reg_wdata_i[5:4]);
        end
    end

    assign clr_req = reg_wr_i & reg_addr_i & reg_wdata_i[0];

    cmp_sync #(.STAGES(SYNC_STAGES)) sync_i (
        .clk_i (clk_i),
        .rst_ni(rst_ni),
        .d_i   (cmp_raw_i),
        .q_o   (sync_val)
    );

    cmp_hold_gate #(.HOLD_CYCLES(HOLD_CYCLES)) hold_i (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .en_i   (en_q),
        .sync_i (sync_val),
        .gated_o(gated),
        .state_o(hold_state),
        .cnt_o  (hold_cnt)
    );

    cmp_edge_flag edge_i (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .gated_i(gated),
        .mode_i (mode_q),
        .clr_i  (clr_req),
        .flag_o (flag)
    );

    always_comb begin
        if (reg_addr_i) reg_rdata_o = {6'b0, gated, flag};
        else            reg_rdata_o = {2'b0, mode_q, pin_q, cap_q, ie_q, en_q};
    end

    assign irq_o     = ie_q & flag;
    assign capture_o = cap_q & gated;
    assign pin_o     = pin_q & cmp_raw_i;
endmodule

// File: rtl/cmp_event_ctrl_chk.sv
`timescale 1ns/1ps
module cmp_event_ctrl_chk
    import cmp_evt_pkg::*;
#(
    parameter int HOLD_CYCLES = 63,
    localparam int CNT_W = $clog2(HOLD_CYCLES + 1)
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             en_q,
    input  hold_state_e      hold_state,
    input  logic [CNT_W-1:0] hold_cnt,
    input  logic             gated,
    input  logic             flag,
    input  logic             clr_req,
    input  evt_mode_e        mode_q
);
    assert_settle_frozen_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (hold_state == ST_SETTLE) |=> $stable(gated));

    assert_cnt_in_window_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        hold_cnt < CNT_W'(HOLD_CYCLES));

    assert_gate_only_tracking_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !$stable(gated) |-> ($past(hold_state) == ST_TRACK));

    assert_flag_sticky_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (flag && !clr_req) |=> flag);

    assert_mode_off_quiet_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (mode_q == EVT_NONE && !flag) |=> !flag);

    assert_disable_to_off_R14: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !en_q |=> (hold_state == ST_OFF));
endmodule

bind cmp_event_ctrl cmp_event_ctrl_chk #(.HOLD_CYCLES(HOLD_CYCLES)) chk_i (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .en_q      (en_q),
    .hold_state(hold_state),
    .hold_cnt  (hold_cnt),
    .gated     (gated),
    .flag      (flag),
    .clr_req   (clr_req),
    .mode_q    (mode_q)
);

// File: tb/cmp_event_ctrl_tb_top.sv
`timescale 1ns/1ps
module cmp_event_ctrl_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       raw = 1'b0;
    logic       wr = 1'b0;
    logic       addr = 1'b0;
    logic [7:0] wdata = 8'h00;
    logic [7:0] rdata;
    logic       irq, cap, pin;
    int total = 0;
    int bad = 0;
    bit done = 0;

    always #4 clk = ~clk;

    cmp_event_ctrl dut_i (
        .clk_i(clk), .rst_ni(rst_n), .cmp_raw_i(raw),
        .reg_wr_i(wr), .reg_addr_i(addr), .reg_wdata_i(wdata),
        .reg_rdata_o(rdata), .irq_o(irq), .capture_o(cap), .pin_o(pin)
    );

    // {mode[1:0], start level, end level, expected flag}
    localparam logic [4:0] VEC [8] = '{
        {2'b01, 1'b0, 1'b1, 1'b1},
        {2'b01, 1'b1, 1'b0, 1'b0},
        {2'b10, 1'b0, 1'b1, 1'b0},
        {2'b10, 1'b1, 1'b0, 1'b1},
        {2'b11, 1'b0, 1'b1, 1'b1},
        {2'b11, 1'b1, 1'b0, 1'b1},
        {2'b00, 1'b0, 1'b1, 1'b0},
        {2'b00, 1'b1, 1'b0, 1'b0}
    };

    task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic reg_write(input logic a, input logic [7:0] d);
        @(negedge clk);
        wr = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        wr = 1'b0; wdata = 8'h00;
    endtask

    task automatic status(output logic [7:0] s);
        addr = 1'b1;
        #1 s = rdata;
    endtask

    task automatic cycles(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        logic [7:0] s;
        cycles(3);
        rst_n = 1'b1;
        cycles(1);
        // R1 reset state
        addr = 1'b0; #1 check("R1 ctrl", rdata, 8'h00);
        status(s); check("R1 status", s, 8'h00);
        check("R1 outs", {5'b0, irq, cap, pin}, 8'h00);

        // R3/R4: result high during hold, rising mode
        raw = 1'b1;
        reg_write(1'b0, 8'h11);
        cycles(55);
        status(s); check("R3 frozen in window", s, 8'h00);
        cycles(15);
        status(s); check("R4 flag after window", s, 8'h03);

        // R13 capture and pin
        reg_write(1'b0, 8'h1D);
        #1 check("R13 cap/pin high", {6'b0, cap, pin}, 8'h03);
        raw = 1'b0;
        #1 check("R13 pin raw, R2 cap lags", {6'b0, cap, pin}, 8'h02);
        cycles(5);
        check("R13 cap follows gated", {7'b0, cap}, 8'h00);

        // R12 irq gating (flag still set)
        check("R12 irq off without enable", {7'b0, irq}, 8'h00);
        reg_write(1'b0, 8'h13);
        #1 check("R12 irq on", {7'b0, irq}, 8'h01);

        // R10 write-one-to-clear
        reg_write(1'b1, 8'h00);
        status(s); check("R10 write 0 keeps flag", {7'b0, s[0]}, 8'h01);
        reg_write(1'b1, 8'h01);
        status(s); check("R10 write 1 clears", {7'b0, s[0]}, 8'h00);

        // R6..R9 vector table
        foreach (VEC[i]) begin
            reg_write(1'b0, {2'b0, VEC[i][4:3], 4'b0011});
            raw = VEC[i][2];
            cycles(6);
            reg_write(1'b1, 8'h01);
            raw = VEC[i][1];
            cycles(6);
            status(s);
            check($sformatf("R6/R7/R8/R9 vec%0d flag", i), {7'b0, s[0]}, {7'b0, VEC[i][0]});
            check($sformatf("R12 vec%0d irq", i), {7'b0, irq}, {7'b0, VEC[i][0]});
        end

        // R11 event and clear in the same cycle
        reg_write(1'b0, 8'h31);
        raw = 1'b0;
        cycles(6);
        reg_write(1'b1, 8'h01);
        raw = 1'b1;            // sync A, sync B, gated C, flag at D
        cycles(3);
        wr = 1'b1; addr = 1'b1; wdata = 8'h01;
        @(negedge clk);
        wr = 1'b0; wdata = 8'h00;
        status(s); check("R11 event beats clear", {7'b0, s[0]}, 8'h01);

        // R14 disabled: gated frozen, no flag
        reg_write(1'b1, 8'h01);
        reg_write(1'b0, 8'h30);
        raw = 1'b0;
        cycles(10);
        raw = 1'b1;
        cycles(10);
        status(s); check("R14 frozen while off", s, 8'h02);

        // R5 re-enable with opposite result, falling mode
        reg_write(1'b0, 8'h20);
        raw = 1'b0;
        cycles(5);
        reg_write(1'b0, 8'h21);
        cycles(40);
        status(s); check("R5 held during window", s, 8'h02);
        cycles(35);
        status(s); check("R5 falling flagged after window", s, 8'h01);

        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog expired");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule